// File: doc/BRIEF.md
# Byte-Accessed Capture/Compare Timer

A 16-bit free-running counter with two input-capture channels and two output-compare channels. Software reaches it through an 8-bit register bus, so every 16-bit quantity is split into a high byte and a low byte. An interlock ties each pair of byte accesses together. Once the high byte of a function has been touched, that function stays suspended until its low byte is accessed. A pair of byte reads or writes therefore always sees, or installs, one coherent 16-bit value.

Each capture channel watches one input pin. On the edge or edges chosen in the control register, it copies the counter into its capture register and raises a sticky flag. Each compare channel drives one output pin. When the counter steps onto the channel's compare value, the channel applies the programmed pin action and raises a sticky flag. The counter advances once for each cycle in which the clock-enable input is high.

Top module: `tmr_capcmp`

## Requirements
- R1: The counter resets to 0 and adds 1 (modulo 2^16) at each clock edge where `tick_i` is high. It holds its value when `tick_i` is low. It reads as high byte at address 0 and low byte at address 1.
- R2: A read of address 0 stores the counter's low byte as it stood in that cycle. Until address 1 is read, address 1 returns that stored byte. When nothing is stored, address 1 returns the live low byte.
- R3: Control bits [1:0] set the channel 0 edge and bits [3:2] set the channel 1 edge: 00 off, 01 rising, 10 falling, 11 both. On a selected edge of `cap_pin_i[n]`, as seen between two consecutive clock edges, capture register n loads the counter value of that cycle and flag bit n sets. Capture registers read at addresses 2/3 for channel 0 and 4/5 for channel 1, high byte first.
- R4: A read of a capture high byte blocks captures on that channel, from that cycle until the cycle after its low byte is read. Blocked edges set no flag and leave the register unchanged.
- R5: Control bits [5:4] set the channel 0 action and bits [7:6] set the channel 1 action: 00 none, 01 set, 10 clear, 11 toggle. The action applies to `cmp_pin_o[n]` at the edge where `tick_i` is high and the counter's next value equals compare register n. At that same edge flag bit 2+n sets. The pins reset to 0.
- R6: A write to a compare high byte (address 6 for channel 0, 8 for channel 1) suspends matching on that channel. Matching resumes after the write to the low byte (address 7 or 9). Compare registers read back at the same addresses.
- R7: The flag register at address 11 holds capture flags in bits [1:0] and compare flags in bits [3:2]. Writing 1 to a bit clears it. A new event in the same cycle wins over the clear.
- R8: After reset, all registers read 0 and both compare pins are 0.
- R9: The control register at address 10 is read/write. Writes to read-only or unmapped addresses change nothing. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter clock enable |
| re_i | input | 1 | Read strobe for the register at addr_i |
| we_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| cap_pin_i | input | 2 | Capture inputs, one per channel |
| cmp_pin_o | output | 2 | Compare outputs, one per channel |

## Verification
The hardest case to reach is a compare match that falls inside an interlock window. The counter has to step onto the compare value while the high byte has been written and the low byte has not. The stimulus therefore writes compare values only a few counts ahead of a bench-side counter model, and sometimes leaves out the low-byte write. Capture holds are exercised the same way: high-byte reads are mixed with random pin toggles, so edges arrive while a channel is blocked.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_CAP  = 2;
  localparam int unsigned N_CMP  = 2;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned N_FLAG = N_CAP + N_CMP;

  localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd1;
  localparam logic [ADDR_W-1:0] A_CAP_HI0 = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMP_HI0 = 4'd6;
  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd10;
  localparam logic [ADDR_W-1:0] A_FLAG    = 4'd11;

  typedef enum logic [1:0] {EDGE_OFF = 2'b00, EDGE_RISE = 2'b01,
                            EDGE_FALL = 2'b10, EDGE_BOTH = 2'b11} edge_sel_e;
  typedef enum logic [1:0] {ACT_NONE = 2'b00, ACT_SET = 2'b01,
                            ACT_CLR = 2'b10, ACT_TGL = 2'b11} cmp_act_e;
endpackage

// File: rtl/tmr_cap_ch.sv
module tmr_cap_ch
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  edge_sel_e        edge_sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rd_hi_i,
  input  logic             rd_lo_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             hold_o,
  output logic             evt_o
);
  logic pin_q, rise, fall, hit;

  assign rise = pin_i & ~pin_q;
  assign fall = ~pin_i & pin_q;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  // a high-byte read in the same cycle already freezes the register
  assign evt_o = hit & ~hold_o & ~rd_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      cap_o  <= '0;
      hold_o <= 1'b0;
    end else begin
      pin_q <= pin_i;
      if (evt_o) cap_o <= cnt_i;
      if (rd_hi_i)      hold_o <= 1'b1;
      else if (rd_lo_i) hold_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_cmp_ch.sv
module tmr_cmp_ch
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  input  cmp_act_e          act_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              hold_o,
  output logic              evt_o,
  output logic              pin_o
);
  assign evt_o = tick_i & (cnt_nxt_i == cmp_o) & ~hold_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o  <= '0;
      hold_o <= 1'b0;
      pin_o  <= 1'b0;
    end else begin
      if (wr_hi_i) begin
        cmp_o[CNT_W-1:BYTE_W] <= wdata_i;
        hold_o <= 1'b1;
      end else if (wr_lo_i) begin
        cmp_o[BYTE_W-1:0] <= wdata_i;
        hold_o <= 1'b0;
      end
      if (evt_o) begin
        unique case (act_i)
          ACT_SET: pin_o <= 1'b1;
          ACT_CLR: pin_o <= 1'b0;
          ACT_TGL: pin_o <= ~pin_o;
          default: pin_o <= pin_o;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [N_CAP-1:0]  cap_pin_i,
  output logic [N_CMP-1:0]  cmp_pin_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [BYTE_W-1:0] lo_lat_q, ctrl_q;
  logic              lo_lat_v_q;
  logic [N_FLAG-1:0] flags_q, flag_set, flag_clr;
  logic [N_CAP-1:0][CNT_W-1:0] cap_val;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_val;
  logic [N_CAP-1:0]  cap_hold, cap_evt;
  logic [N_CMP-1:0]  cmp_hold, cmp_evt;

  assign cnt_nxt  = cnt_q + 1'b1;
  assign flag_set = {cmp_evt, cap_evt};
  assign flag_clr = (we_i && addr_i == A_FLAG) ? wdata_i[N_FLAG-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      lo_lat_q   <= '0;
      lo_lat_v_q <= 1'b0;
      ctrl_q     <= '0;
      flags_q    <= '0;
    end else begin
      if (tick_i) cnt_q <= cnt_nxt;
      if (re_i && addr_i == A_CNT_HI) begin
        lo_lat_q   <= cnt_q[BYTE_W-1:0];
        lo_lat_v_q <= 1'b1;
      end else if (re_i && addr_i == A_CNT_LO) begin
        lo_lat_v_q <= 1'b0;
      end
      if (we_i && addr_i == A_CTRL) ctrl_q <= wdata_i;
      flags_q <= (flags_q & ~flag_clr) | flag_set;
    end
  end

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap
    localparam logic [ADDR_W-1:0] HI = A_CAP_HI0 + ADDR_W'(2 * i);
    tmr_cap_ch u_cap (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (cap_pin_i[i]),
      .edge_sel_i (edge_sel_e'(ctrl_q[2*i +: 2])),
      .cnt_i      (cnt_q),
      .rd_hi_i    (re_i && addr_i == HI),
      .rd_lo_i    (re_i && addr_i == HI + 1'b1),
      .cap_o      (cap_val[i]),
      .hold_o     (cap_hold[i]),
      .evt_o      (cap_evt[i])
    );
  end

  for (genvar j = 0; j < N_CMP; j++) begin : g_cmp
    localparam logic [ADDR_W-1:0] HI = A_CMP_HI0 + ADDR_W'(2 * j);
    tmr_cmp_ch u_cmp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .cnt_nxt_i (cnt_nxt),
      .act_i     (cmp_act_e'(ctrl_q[2*N_CAP + 2*j +: 2])),
      .wr_hi_i   (we_i && addr_i == HI),
      .wr_lo_i   (we_i && addr_i == HI + 1'b1),
      .wdata_i   (wdata_i),
      .cmp_o     (cmp_val[j]),
      .hold_o    (cmp_hold[j]),
      .evt_o     (cmp_evt[j]),
      .pin_o     (cmp_pin_o[j])
    );
  end

  always_comb begin
    unique case (addr_i)
      4'd0:    rdata_o = cnt_q[CNT_W-1:BYTE_W];
      4'd1:    rdata_o = lo_lat_v_q ? lo_lat_q : cnt_q[BYTE_W-1:0];
      4'd2:    rdata_o = cap_val[0][CNT_W-1:BYTE_W];
      4'd3:    rdata_o = cap_val[0][BYTE_W-1:0];
      4'd4:    rdata_o = cap_val[1][CNT_W-1:BYTE_W];
      4'd5:    rdata_o = cap_val[1][BYTE_W-1:0];
      4'd6:    rdata_o = cmp_val[0][CNT_W-1:BYTE_W];
      4'd7:    rdata_o = cmp_val[0][BYTE_W-1:0];
      4'd8:    rdata_o = cmp_val[1][CNT_W-1:BYTE_W];
      4'd9:    rdata_o = cmp_val[1][BYTE_W-1:0];
      4'd10:   rdata_o = ctrl_q;
      4'd11:   rdata_o = {{(BYTE_W-N_FLAG){1'b0}}, flags_q};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_capcmp_chk.sv
module tmr_capcmp_chk
  import tmr_pkg::*;
(
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        tick_i,
  input logic                        we_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [N_CMP-1:0]            cmp_pin_o,
  input logic [CNT_W-1:0]            cnt_q,
  input logic [N_CAP-1:0][CNT_W-1:0] cap_val,
  input logic [N_CAP-1:0]            cap_hold,
  input logic [N_CMP-1:0]            cmp_hold,
  input logic [N_FLAG-1:0]           flags_q
);
  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + 1'b1);
  // R1
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  // R4
  cap0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hold[0] |=> $stable(cap_val[0]));
  // R4
  cap1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hold[1] |=> $stable(cap_val[1]));
  // R6
  cmp0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_hold[0] |=> $stable(cmp_pin_o[0]));
  // R6
  cmp1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_hold[1] |=> $stable(cmp_pin_o[1]));
  // R5
  pin_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cmp_pin_o));
  // R7
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(flags_q) & ~flags_q)) |-> ($past(we_i) && $past(addr_i) == A_FLAG));
endmodule

bind tmr_capcmp tmr_capcmp_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .cmp_pin_o (cmp_pin_o),
  .cnt_q     (cnt_q),
  .cap_val   (cap_val),
  .cap_hold  (cap_hold),
  .cmp_hold  (cmp_hold),
  .flags_q   (flags_q)
);

// File: tb/tmr_capcmp_tb_top.sv
`timescale 1ns/1ps
module tmr_capcmp_tb_top;
  logic       clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, re_i = 1'b0, we_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic [1:0] cap_pin_i = '0, cmp_pin_o;

  tmr_capcmp dut_i (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;

  // reference model of the register-visible state
  logic [15:0] m_cnt, m_cap[2], m_cmp[2];
  logic [7:0]  m_lat, m_ctrl;
  logic        m_latv;
  logic [1:0]  m_caph, m_cmph, m_pin, m_pinq;
  logic [3:0]  m_flags;

  task automatic m_reset();
    m_cnt = '0; m_lat = '0; m_latv = 0; m_ctrl = '0; m_flags = '0;
    m_caph = '0; m_cmph = '0; m_pin = '0; m_pinq = '0;
    for (int k = 0; k < 2; k++) begin m_cap[k] = '0; m_cmp[k] = '0; end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0:  return m_cnt[15:8];
      4'd1:  return m_latv ? m_lat : m_cnt[7:0];
      4'd2:  return m_cap[0][15:8];
      4'd3:  return m_cap[0][7:0];
      4'd4:  return m_cap[1][15:8];
      4'd5:  return m_cap[1][7:0];
      4'd6:  return m_cmp[0][15:8];
      4'd7:  return m_cmp[0][7:0];
      4'd8:  return m_cmp[1][15:8];
      4'd9:  return m_cmp[1][7:0];
      4'd10: return m_ctrl;
      4'd11: return {4'b0, m_flags};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] a);
    case (a)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4, 4'd5: return "R3/R4";
      4'd6, 4'd7, 4'd8, 4'd9: return "R6";
      4'd11: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic m_step();
    logic [15:0] nxt;
    logic [3:0]  set, clr;
    logic        hit, rise, fall;
    logic [1:0]  es, act;
    nxt = m_cnt + 16'd1;
    set = '0;
    clr = (we_i && addr_i == 4'd11) ? wdata_i[3:0] : 4'd0;
    for (int k = 0; k < 2; k++) begin
      rise = cap_pin_i[k] & ~m_pinq[k];
      fall = ~cap_pin_i[k] & m_pinq[k];
      es = m_ctrl[2*k +: 2];
      hit = (es == 2'b01) ? rise : (es == 2'b10) ? fall : (es == 2'b11) ? (rise | fall) : 1'b0;
      if (hit && !m_caph[k] && !(re_i && addr_i == 4'(2 + 2*k))) begin
        m_cap[k] = m_cnt;
        set[k] = 1'b1;
      end
      if (re_i && addr_i == 4'(2 + 2*k)) m_caph[k] = 1'b1;
      else if (re_i && addr_i == 4'(3 + 2*k)) m_caph[k] = 1'b0;
    end
    for (int k = 0; k < 2; k++) begin
      act = m_ctrl[4 + 2*k +: 2];
      if (tick_i && nxt == m_cmp[k] && !m_cmph[k]) begin
        set[2+k] = 1'b1;
        case (act)
          2'b01: m_pin[k] = 1'b1;
          2'b10: m_pin[k] = 1'b0;
          2'b11: m_pin[k] = ~m_pin[k];
          default: ;
        endcase
      end
      if (we_i && addr_i == 4'(6 + 2*k)) begin m_cmp[k][15:8] = wdata_i; m_cmph[k] = 1'b1; end
      else if (we_i && addr_i == 4'(7 + 2*k)) begin m_cmp[k][7:0] = wdata_i; m_cmph[k] = 1'b0; end
    end
    if (re_i && addr_i == 4'd0) begin m_lat = m_cnt[7:0]; m_latv = 1'b1; end
    else if (re_i && addr_i == 4'd1) m_latv = 1'b0;
    if (we_i && addr_i == 4'd10) m_ctrl = wdata_i;
    m_flags = (m_flags & ~clr) | set;
    m_pinq = cap_pin_i;
    if (tick_i) m_cnt = nxt;
  endtask

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) m_reset(); else m_step();

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle, then check outputs against the model before the next edge
  task automatic cyc(input logic re, input logic we, input logic [3:0] a,
                     input logic [7:0] d, input logic tk, input logic [1:0] p);
    @(negedge clk_i);
    re_i = re; we_i = we; addr_i = a; wdata_i = d; tick_i = tk; cap_pin_i = p;
    #1;
    check(rdata_o == exp_rd(a), req_of(a), rdata_o, exp_rd(a));
    check(cmp_pin_o == m_pin, "R5", cmp_pin_o, m_pin);
  endtask

  task automatic idle(input int n, input logic [1:0] p);
    for (int k = 0; k < n; k++) cyc(0, 0, 4'd11, 8'h00, 1'b1, p);
  endtask

  initial begin
    #(190000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] tgt;
    logic [1:0]  pins;
    void'($urandom(32'd4711));
    m_reset();
    // R8: reset state on every address
    #3;
    for (int a = 0; a < 16; a++) begin
      addr_i = 4'(a); #1;
      check(rdata_o == 8'h00, "R8", rdata_o, 0);
    end
    check(cmp_pin_o == 2'b00, "R8", cmp_pin_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R6: compare high write alone holds off the match
    cyc(0, 1, 4'd10, 8'h31, 1, 2'b00);           // ch0 toggle, ch0 rising edge
    tgt = m_cnt + 16'd10;
    cyc(0, 1, 4'd6, tgt[15:8], 1, 2'b00);
    idle(30, 2'b00);
    check(cmp_pin_o[0] == 1'b0, "R6", cmp_pin_o[0], 0);
    tgt = m_cnt + 16'd10;
    cyc(0, 1, 4'd6, tgt[15:8], 1, 2'b00);
    cyc(0, 1, 4'd7, tgt[7:0], 1, 2'b00);
    idle(20, 2'b00);
    check(cmp_pin_o[0] == 1'b1, "R5", cmp_pin_o[0], 1);
    cyc(0, 0, 4'd11, 8'h00, 1, 2'b00);
    check(rdata_o[2] == 1'b1, "R7", rdata_o[2], 1);
    cyc(0, 1, 4'd11, 8'h0F, 1, 2'b00);
    cyc(0, 0, 4'd11, 8'h00, 1, 2'b00);
    check(rdata_o == 8'h00, "R7", rdata_o, 0);

    // R4: capture blocked after high-byte read
    cyc(1, 0, 4'd2, 8'h00, 1, 2'b00);
    cyc(0, 0, 4'd11, 8'h00, 1, 2'b01);
    cyc(0, 0, 4'd11, 8'h00, 1, 2'b01);
    check(rdata_o[0] == 1'b0, "R4", rdata_o[0], 0);
    cyc(1, 0, 4'd3, 8'h00, 1, 2'b00);
    cyc(0, 0, 4'd11, 8'h00, 1, 2'b01);
    cyc(0, 0, 4'd11, 8'h00, 1, 2'b01);
    check(rdata_o[0] == 1'b1, "R3", rdata_o[0], 1);

    // R2: high read then low read pairs across ticks
    cyc(1, 0, 4'd0, 8'h00, 1, 2'b00);
    idle(3, 2'b00);
    cyc(1, 0, 4'd1, 8'h00, 1, 2'b00);
    // R9: write to read-only address has no effect
    cyc(0, 1, 4'd3, 8'hA5, 1, 2'b00);
    cyc(0, 0, 4'd3, 8'h00, 1, 2'b00);

    // R1: full counter wrap
    for (int k = 0; k < 65600; k++) cyc(0, 0, 4'd0, 8'h00, 1, 2'b00);

    // constrained random mix
    pins = 2'b00;
    for (int k = 0; k < 20000; k++) begin
      int unsigned r;
      logic tk;
      r = $urandom_range(0, 99);
      tk = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 3) == 0) pins = 2'($urandom);
      if (r < 30) cyc(1, 0, 4'($urandom_range(0, 13)), 8'h00, tk, pins);
      else if (r < 45) begin
        int unsigned ch;
        ch = $urandom_range(0, 1);
        tgt = m_cnt + 16'($urandom_range(2, 40));
        cyc(0, 1, 4'(6 + 2*ch), tgt[15:8], tk, pins);
        if ($urandom_range(0, 3) != 0) cyc(0, 1, 4'(7 + 2*ch), tgt[7:0], tk, pins);
      end
      else if (r < 50) cyc(0, 1, 4'd10, 8'($urandom), tk, pins);
      else if (r < 60) cyc(0, 1, 4'd11, 8'($urandom), tk, pins);
      else if (r < 63) cyc(0, 1, 4'($urandom_range(0, 15)), 8'($urandom), tk, pins);
      else cyc(0, 0, 4'($urandom_range(0, 15)), 8'h00, tk, pins);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule